// File: doc/BRIEF.md
# Pseudo-SRAM Access Sequencer

This block turns single-beat host requests into correctly timed strobe sequences for a 2M x 16 asynchronous pseudo-SRAM. The host side is simple. When `hostReady` is high and `hostReq` is raised, the block takes the flag, address, write data and byte enables on that clock edge. It later pulses `hostDone` for one cycle, and for a read `hostRdata` is valid at that point.

The memory holds a DRAM core behind an SRAM-style pin interface, so timing rules beyond those of a plain SRAM apply. The output enable must already be high when a write opens, or the part starts a read. Active phases have an upper bound. Byte masking does not exist on reads. Every minimum time is a clock-cycle parameter:

- `CYCLE_CLKS`: the chip-enable low phase of every access.
- `PULSE_CLKS`: the write-enable pulse.
- `ACCESS_CLKS`: the delay before read data is sampled.
- `GAP_CLKS`: the idle time between accesses.
- `MAX_LOW_CLKS`: the bound on any active phase.

The data bus is split into `memDqOut`, `memDqIn` and `memDqOe` so that the pad tri-state sits outside the block.

Top module: `psram_sequencer`

## Requirements
- R1: While reset is held, `memCeN`, `memWeN`, `memOeN`, `memLbN` and `memUbN` are all 1, `memDqOe` is 0 and `hostReady` is 1.
- R2: A read drives `memCeN` and `memOeN` low on the acceptance edge, with the request address on `memAddr`. It also drives both `memLbN` and `memUbN` low, whatever `hostBe` holds. It captures `memDqIn` into `hostRdata` `ACCESS_CLKS` cycles after that edge.
- R3: A write drives `memLbN` low only if `hostBe[0]` is 1, which selects data bits 7:0. It drives `memUbN` low only if `hostBe[1]` is 1, which selects bits 15:8. The byte lane that is not selected keeps its stored value.
- R4: `memOeN` stays high through every write and has been high for at least one cycle when `memWeN` falls. `memWeN` and `memOeN` are never low together.
- R5: In a write, `memWeN` is low for exactly `PULSE_CLKS` cycles from the acceptance edge. `memDqOe` is set on the acceptance edge and clears one cycle after `memWeN` rises, while `memCeN` is still low.
- R6: Every access holds `memCeN` low for exactly `CYCLE_CLKS` cycles. `hostDone` is a one-cycle pulse that becomes visible `CYCLE_CLKS` cycles after the acceptance edge.
- R7: `hostReady` is low from the acceptance edge until `GAP_CLKS` cycles after `memCeN` returns high. `memCeN` therefore stays high for at least `GAP_CLKS`+1 cycles between accesses.
- R8: A request raised while `hostReady` is low is ignored. The address, data, flag and enables are taken only at acceptance, so later changes on the host inputs do not affect the access in progress.
- R9: `memCeN` is never low for more than `MAX_LOW_CLKS` consecutive cycles.
- R10: `memDqOe` is never 1 while `memOeN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostReq | input | 1 | Request strobe, taken when hostReady is high |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 21 | Word address |
| hostWdata | input | 16 | Write data |
| hostBe | input | 2 | Byte enables for writes (bit 0 low byte, bit 1 high byte) |
| hostReady | output | 1 | Block idle and able to take a request |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | 16 | Read data, valid from hostDone of a read |
| memAddr | output | 21 | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memLbN | output | 1 | Lower byte select, active low |
| memUbN | output | 1 | Upper byte select, active low |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqIn | input | 16 | Data returned by the memory |
| memDqOe | output | 1 | Drive enable for memDqOut |

## Verification
The bench pairs the sequencer with a behavioural memory. The memory returns a poison value until 65 ns after chip enable falls, so a sequencer that samples too early reads garbage instead of the stored word. Each of the 23 walking-one and boundary addresses is written before any is read back, so a dropped or swapped address bit shows up as aliased data. Upper-only and lower-only writes are followed by reads that expose a clobbered neighbour lane. A read issued with both enables clear still has to return the full word.

A request is held high, with changing data, throughout a busy cycle. A design that re-accepts during the busy cycle, or that forwards the host inputs instead of latching them, completes twice or stores the wrong word. Edge timers in the model catch several further faults: an output enable that falls before a write, a short write pulse, data released before the write pulse ends, bus drive overlapping the output enable, and a short or over-long chip-enable phase.

// File: rtl/psram_seq_pkg.sv
`timescale 1ns/1ps
package psram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WREC,
    ST_GAP
  } seqState_t;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic take;     // accept request: latch host fields, set lanes and drive
    logic capture;  // sample memory read data
    logic dropBus;  // stop driving the data bus
    logic finish;   // end of access: release byte lanes
  } dpStrobe_t;

endpackage

// File: rtl/psram_seq_ctrl.sv
`timescale 1ns/1ps
module psram_seq_ctrl
  import psram_seq_pkg::*;
#(
  parameter int CYCLE_CLKS   = 7,
  parameter int PULSE_CLKS   = 5,
  parameter int ACCESS_CLKS  = 7,
  parameter int GAP_CLKS     = 2,
  parameter int MAX_LOW_CLKS = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostWrite,
  output logic       hostReady,
  output logic       hostDone,
  output logic       memCeN,
  output logic       memWeN,
  output logic       memOeN,
  output dpStrobe_t  strobe
);

  localparam int CNT_MAX = (CYCLE_CLKS > GAP_CLKS) ? CYCLE_CLKS + 1 : GAP_CLKS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CYC_END  = CNT_W'(CYCLE_CLKS);
  localparam logic [CNT_W-1:0] PUL_END  = CNT_W'(PULSE_CLKS);
  localparam logic [CNT_W-1:0] DROP_AT  = CNT_W'(PULSE_CLKS + 1);
  localparam logic [CNT_W-1:0] ACC_AT   = CNT_W'(ACCESS_CLKS);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_CLKS);
  localparam int LOW_W = $clog2(MAX_LOW_CLKS + 2);

  initial begin
    assert (PULSE_CLKS >= 1 && PULSE_CLKS + 1 <= CYCLE_CLKS)
      else $error("write pulse must leave at least one recovery cycle");
    assert (ACCESS_CLKS >= 1 && ACCESS_CLKS <= CYCLE_CLKS)
      else $error("read sample point must lie inside the access");
    assert (GAP_CLKS >= 1) else $error("inter-access gap must be at least one cycle");
    assert (CYCLE_CLKS <= MAX_LOW_CLKS) else $error("access exceeds active-phase bound");
  end

  seqState_t        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      hostDone <= 1'b0;
    end else begin
      hostDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (hostReq) begin
            memCeN <= 1'b0;
            cnt    <= CNT_W'(1);
            if (hostWrite) begin
              memWeN <= 1'b0;
              state  <= ST_WPULSE;
            end else begin
              memOeN <= 1'b0;
              state  <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (cnt == CYC_END) begin
            memCeN   <= 1'b1;
            memOeN   <= 1'b1;
            hostDone <= 1'b1;
            cnt      <= CNT_W'(1);
            state    <= ST_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WPULSE: begin
          cnt <= cnt + 1'b1;
          if (cnt == PUL_END) begin
            memWeN <= 1'b1;
            state  <= ST_WREC;
          end
        end
        ST_WREC: begin
          if (cnt == CYC_END) begin
            memCeN   <= 1'b1;
            hostDone <= 1'b1;
            cnt      <= CNT_W'(1);
            state    <= ST_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == GAP_END) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign hostReady = (state == ST_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.take    = (state == ST_IDLE) && hostReq;
    strobe.capture = (state == ST_READ) && (cnt == ACC_AT);
    strobe.dropBus = (state == ST_WREC) && (cnt == DROP_AT);
    strobe.finish  = ((state == ST_READ) || (state == ST_WREC)) && (cnt == CYC_END);
  end

  // Checker state: length of the current chip-enable low run.
  logic [LOW_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    lowRun <= '0;
    else if (!memCeN) begin
      if (lowRun != {LOW_W{1'b1}}) lowRun <= lowRun + 1'b1;
    end else                      lowRun <= '0;
  end

  assert_ce_low_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= LOW_W'(MAX_LOW_CLKS));

  assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> (memOeN && $past(memOeN)));

  assert_no_we_oe_overlap_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !hostReady);

  assert_gap_min_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |=> memCeN);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

endmodule

// File: rtl/psram_seq_datapath.sv
`timescale 1ns/1ps
module psram_seq_datapath
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [1:0]        hostBe,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      memDqOut  <= '0;
      memDqOe   <= 1'b0;
      memLbN    <= 1'b1;
      memUbN    <= 1'b1;
      hostRdata <= '0;
    end else begin
      if (strobe.take) begin
        memAddr  <= hostAddr;
        memDqOut <= hostWdata;
        memDqOe  <= hostWrite;
        // Reads always enable both lanes; writes follow the enables.
        memLbN   <= hostWrite ? !hostBe[0] : 1'b0;
        memUbN   <= hostWrite ? !hostBe[1] : 1'b0;
      end
      if (strobe.dropBus) memDqOe <= 1'b0;
      if (strobe.finish) begin
        memDqOe <= 1'b0;
        memLbN  <= 1'b1;
        memUbN  <= 1'b1;
      end
      if (strobe.capture) hostRdata <= memDqIn;
    end
  end

  assert_drive_spans_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |=> memDqOe);

endmodule

// File: rtl/psram_sequencer.sv
`timescale 1ns/1ps
module psram_sequencer
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int DATA_W       = 16,
  parameter int CYCLE_CLKS   = 7,
  parameter int PULSE_CLKS   = 5,
  parameter int ACCESS_CLKS  = 7,
  parameter int GAP_CLKS     = 2,
  parameter int MAX_LOW_CLKS = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [1:0]        hostBe,
  output logic              hostReady,
  output logic              hostDone,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  dpStrobe_t strobe;

  psram_seq_ctrl #(
    .CYCLE_CLKS  (CYCLE_CLKS),
    .PULSE_CLKS  (PULSE_CLKS),
    .ACCESS_CLKS (ACCESS_CLKS),
    .GAP_CLKS    (GAP_CLKS),
    .MAX_LOW_CLKS(MAX_LOW_CLKS)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hostReady(hostReady),
    .hostDone (hostDone),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .strobe   (strobe)
  );

  psram_seq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostWrite(hostWrite),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostBe   (hostBe),
    .hostRdata(hostRdata),
    .memAddr  (memAddr),
    .memLbN   (memLbN),
    .memUbN   (memUbN),
    .memDqOut (memDqOut),
    .memDqIn  (memDqIn),
    .memDqOe  (memDqOe)
  );

  assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  assert_read_lanes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !memOeN) |-> (!memLbN && !memUbN));

  assert_drive_inside_access_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !memCeN);

endmodule

// File: tb/psram_sequencer_test.sv
`timescale 1ns/1ps
module psram_sequencer_test;

  localparam int AW = 21, DW = 16;
  localparam int CYC = 7, PUL = 5, ACC = 7, GAP = 2, MAXLOW = 100;

  logic clk = 1'b0;
  logic rstN;
  logic hostReq, hostWrite;
  logic [AW-1:0] hostAddr;
  logic [DW-1:0] hostWdata;
  logic [1:0] hostBe;
  logic hostReady, hostDone;
  logic [DW-1:0] hostRdata;
  logic [AW-1:0] memAddr;
  logic memCeN, memWeN, memOeN, memLbN, memUbN, memDqOe;
  logic [DW-1:0] memDqOut;
  logic [DW-1:0] memDqIn;

  always #5 clk = ~clk;

  psram_sequencer #(
    .ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(CYC), .PULSE_CLKS(PUL),
    .ACCESS_CLKS(ACC), .GAP_CLKS(GAP), .MAX_LOW_CLKS(MAXLOW)
  ) uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .hostReady(hostReady), .hostDone(hostDone), .hostRdata(hostRdata),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memLbN(memLbN), .memUbN(memUbN), .memDqOut(memDqOut), .memDqIn(memDqIn),
    .memDqOe(memDqOe)
  );

  int errors = 0;
  int checks = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [DW-1:0] mem [int unsigned];
  int  epoch = 0;
  logic dataValid = 1'b0;
  time tCeFall = 0, tCeRise = 0, tWeFall = 0, tWeRise = 0, tOeRise = 0, tDrive = 0;
  bit everLow = 0, wroteThis = 0;

  always @(negedge memCeN) begin
    if (everLow)
      chk(($time - tCeRise) >= (GAP + 1) * 10, "R7 chip-enable high gap ns",
          $time - tCeRise, (GAP + 1) * 10);
    everLow   = 1;
    wroteThis = 0;
    tCeFall   = $time;
  end

  always @(posedge memCeN) begin
    dataValid = 1'b0;
    if (everLow) begin
      chk(($time - tCeFall) == CYC * 10, "R6 chip-enable low ns", $time - tCeFall, CYC * 10);
      chk(($time - tCeFall) <= MAXLOW * 10, "R9 active phase bound ns", $time - tCeFall, MAXLOW * 10);
      if (wroteThis)
        chk(($time - tWeRise) >= 10, "R5 write recovery ns", $time - tWeRise, 10);
      tCeRise = $time;
    end
  end

  always @(negedge memCeN) begin
    dataValid = 1'b0;
    #65;
    dataValid = !memCeN;
  end

  always @(posedge memOeN) tOeRise = $time;
  always @(posedge memDqOe) tDrive = $time;

  always @(negedge memWeN) begin
    if (rstN === 1'b1) begin
      tWeFall = $time;
      chk(memOeN === 1'b1 && tOeRise < $time, "R4 output enable high before write",
          {63'd0, memOeN}, 1);
    end
  end

  always @(posedge memWeN) begin
    if (rstN === 1'b1 && memCeN === 1'b0) begin
      logic [DW-1:0] w;
      int unsigned key;
      chk(($time - tWeFall) == PUL * 10, "R5 write pulse ns", $time - tWeFall, PUL * 10);
      chk(memDqOe === 1'b1 && ($time - tDrive) >= 15, "R5 data setup at pulse end ns",
          $time - tDrive, 15);
      key = 32'(memAddr);
      w = mem.exists(key) ? mem[key] : '0;
      if (!memLbN) w[7:0]  = memDqOut[7:0];
      if (!memUbN) w[15:8] = memDqOut[15:8];
      mem[key]  = w;
      wroteThis = 1;
      tWeRise   = $time;
      epoch++;
    end
  end

  always @(dataValid, memOeN, memCeN, memWeN, memAddr, epoch) begin
    if (dataValid && !memOeN && !memCeN && memWeN)
      memDqIn = mem.exists(32'(memAddr)) ? mem[32'(memAddr)] : '0;
    else
      memDqIn = 16'hDEAD;
  end

  always @(posedge clk) begin
    if (rstN === 1'b1) begin
      chk(!(memDqOe && !memOeN), "R10 bus driven under output enable", {63'd0, memDqOe}, 0);
      if (!memCeN && !memOeN)
        chk(!memLbN && !memUbN, "R2 both lanes on read", {62'd0, memUbN, memLbN}, 0);
    end
  end

  // ---------------- host tasks ----------------
  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ {11'h2B5, a[20:16]};
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be, output logic [DW-1:0] rd);
    int lat, g;
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostReq = 1; hostWrite = wr; hostAddr = a; hostWdata = d; hostBe = be;
    @(negedge clk);
    hostReq = 0; hostWdata = ~d; hostAddr = ~a;
    chk(!hostReady, "R7 ready low after acceptance", {63'd0, hostReady}, 0);
    chk(memAddr == a, "R2 address on memory", memAddr, a);
    if (wr) begin
      chk(memLbN == !be[0] && memUbN == !be[1], "R3 write lanes",
          {memUbN, memLbN}, {!be[1], !be[0]});
      chk(memOeN && !memWeN && memDqOe, "R4 write strobes", {memOeN, memWeN, memDqOe}, 3'b101);
    end else begin
      chk(!memOeN && memWeN && !memLbN && !memUbN && !memDqOe, "R2 read strobes",
          {memOeN, memWeN, memLbN, memUbN, memDqOe}, 5'b01000);
    end
    lat = 0;
    while (!hostDone && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == CYC, "R6 done latency", lat, CYC);
    rd = hostRdata;
    @(negedge clk);
    chk(!hostDone, "R6 done is one cycle", {63'd0, hostDone}, 0);
    g = 1;
    while (!hostReady && g < 100) begin
      @(negedge clk);
      g++;
    end
    chk(g == GAP, "R7 ready returns after gap", g, GAP);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic [AW-1:0] addrs [23];
    rstN = 0; hostReq = 0; hostWrite = 0; hostAddr = '0; hostWdata = '0; hostBe = '0;
    repeat (3) @(negedge clk);
    chk(memCeN && memWeN && memOeN && memLbN && memUbN, "R1 strobes idle in reset",
        {memCeN, memWeN, memOeN, memLbN, memUbN}, 5'h1f);
    chk(!memDqOe && hostReady, "R1 bus released and ready", {memDqOe, hostReady}, 2'b01);
    rstN = 1;
    repeat (2) @(negedge clk);

    // Walking-one and boundary addresses: all writes first, then all reads.
    for (int i = 0; i < 21; i++) addrs[i] = AW'(1) << i;
    addrs[21] = '0;
    addrs[22] = '1;
    for (int i = 0; i < 23; i++) access(1, addrs[i], pat(addrs[i]), 2'b11, rd);
    for (int i = 0; i < 23; i++) begin
      access(0, addrs[i], 16'h0, 2'b11, rd);
      chk(rd == pat(addrs[i]), "R2 word readback", rd, pat(addrs[i]));
    end

    // Byte-lane writes (R3).
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] a;
      a = AW'(21'h1000 + i * 37);
      access(1, a, 16'h1234, 2'b11, rd);
      access(1, a, 16'hABCD, 2'b10, rd);
      access(0, a, 16'h0, 2'b11, rd);
      chk(rd == 16'hAB34, "R3 upper-only write", rd, 16'hAB34);
      access(1, a, 16'h99EF, 2'b01, rd);
      access(0, a, 16'h0, 2'b00, rd);
      chk(rd == 16'hABEF, "R3 lower-only write, R2 read ignores enables", rd, 16'hABEF);
    end

    // R8: request held high with changing fields while busy.
    begin
      int dones;
      @(negedge clk);
      while (!hostReady) @(negedge clk);
      hostReq = 1; hostWrite = 1; hostAddr = addrs[3]; hostWdata = 16'h5EED; hostBe = 2'b11;
      @(negedge clk);
      hostWrite = 0; hostAddr = addrs[5]; hostWdata = 16'hBAD0; hostBe = 2'b01;
      dones = 0;
      for (int i = 0; i < CYC + GAP; i++) begin
        if (hostDone) dones++;
        chk(!hostReady, "R8 busy holds off requests", {63'd0, hostReady}, 0);
        if (i == CYC + GAP - 1) hostReq = 0;
        else @(negedge clk);
      end
      chk(dones == 1, "R8 single completion", dones, 1);
      access(0, addrs[3], 16'h0, 2'b11, rd);
      chk(rd == 16'h5EED, "R8 data latched at acceptance", rd, 16'h5EED);
      access(0, addrs[5], 16'h0, 2'b11, rd);
      chk(rd == pat(addrs[5]), "R8 later address untouched", rd, pat(addrs[5]));
    end

    repeat (5) @(negedge clk);
    report();
    $finish;
  end

endmodule